// File: doc/BRIEF.md
# Per-Core Local Interrupt Hub

This block gathers the interrupt sources that belong to each core of a four-core cluster and turns them into one IRQ line per core. Each core has four timer interrupt lines (secure physical, non-secure physical, hypervisor physical and virtual), four mailbox "not empty" flags, its own performance-monitor interrupt, and core 0 also receives a fast interrupt cascaded from a downstream peripheral controller.

Software controls the hub over a simple 32-bit register bus with a combinational read path and a single-cycle write strobe. A per-core timer enable register and a per-core mailbox enable register mask the sources. A cluster-wide routing mask, changed through separate write-1-to-set and write-1-to-clear offsets, decides which cores see their performance-monitor interrupt. A read-only pending word per core shows the sources that are both active and enabled. All sources are level-sensitive and pass through without latching, so a pending bit follows its source.

Top module: `core_irq_hub`

## Requirements
- R1: After reset every control register is 0, so every core_irq bit is 0 and every register reads 0 even with all sources active, except pending bit 8 of core 0.
- R2: The timer enable register of core c sits at byte offset 0x040 + 4c; its bits 3:0 enable timer_lvl[4c+0] (secure physical), [4c+1] (non-secure physical), [4c+2] (hypervisor) and [4c+3] (virtual). It reads back bits 3:0 as written and 0 above.
- R3: The mailbox enable register of core c sits at offset 0x050 + 4c; bit m enables mbox_busy[4c+m]. It reads back bits 3:0 as written and 0 above.
- R4: The pending word of core c is read at offset 0x060 + 4c: bits 3:0 are timer_lvl[4c+3:4c] AND its timer enables, bits 7:4 are mbox_busy[4c+3:4c] AND its mailbox enables, bit 8 the cascaded input, bit 9 the performance-monitor input AND its routing bit; bits 31:10 read 0. Bits follow their sources with no latching.
- R5: Writes to the pending offsets change no register and no output.
- R6: A write to offset 0x010 sets every routing bit whose wdata bit in 3:0 is 1 and leaves the others; routing bit c enables pmu_lvl[c] for core c.
- R7: A write to offset 0x014 clears every routing bit whose wdata bit in 3:0 is 1 and leaves the others.
- R8: Reads of offsets 0x010 and 0x014 return the routing mask in bits 3:0 and 0 above.
- R9: The cascaded input is unmasked and goes to core 0 only: it sets core 0 pending bit 8 and core_irq[0], and pending bit 8 of cores 1 to 3 reads 0.
- R10: core_irq[c] is the OR of core c's pending bits, combinationally.
- R11: Reads of offsets not listed above return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| timer_lvl | input | 16 | Timer interrupt levels, four per core, core c at bits 4c+3:4c |
| mbox_busy | input | 16 | Mailbox non-empty flags, core c mailbox m at bit 4c+m |
| casc_lvl | input | 1 | Fast interrupt from the downstream peripheral controller |
| pmu_lvl | input | 4 | Performance-monitor interrupt, one per core |
| core_irq | output | 4 | IRQ output, one per core |

## Verification
Timers and mailboxes are driven with all lines high while each core gets a different enable pattern, which separates a swapped core index or bit order from a correct mapping; dropping the sources afterwards with enables still set tells level behaviour apart from latching. The routing mask is walked through overlapping set and clear writes, so an overwrite in place of OR, or a clear that touches unselected bits, shows in the read-back and in core_irq. The cascaded input is raised alone to show it reaches core 0 only, and full-ones writes to the pending and unmapped offsets show that neither alters any enable.

// File: rtl/core_irq_hub.sv
module core_irq_hub #(
  parameter int NCORE = 4,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [4*NCORE-1:0] timer_lvl,
  input  logic [4*NCORE-1:0] mbox_busy,
  input  logic               casc_lvl,
  input  logic [NCORE-1:0]   pmu_lvl,
  output logic [NCORE-1:0]   core_irq
);
  localparam int PEND_W = 10;
  localparam logic [AW-1:0] PMU_SET  = AW'('h010);
  localparam logic [AW-1:0] PMU_CLR  = AW'('h014);
  localparam logic [AW-1:0] TMR_BASE = AW'('h040);
  localparam logic [AW-1:0] MBX_BASE = AW'('h050);
  localparam logic [AW-1:0] PND_BASE = AW'('h060);

  logic [4*NCORE-1:0]      tmr_en_q;
  logic [4*NCORE-1:0]      mbx_en_q;
  logic [NCORE-1:0]        route_q;
  logic [PEND_W*NCORE-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_en_q <= '0;
      mbx_en_q <= '0;
      route_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == PMU_SET) route_q <= route_q | bus_wdata[NCORE-1:0];
      if (bus_addr == PMU_CLR) route_q <= route_q & ~bus_wdata[NCORE-1:0];
      for (int c = 0; c < NCORE; c++) begin
        if (bus_addr == TMR_BASE + AW'(4*c)) tmr_en_q[4*c +: 4] <= bus_wdata[3:0];
        if (bus_addr == MBX_BASE + AW'(4*c)) mbx_en_q[4*c +: 4] <= bus_wdata[3:0];
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic casc_here;
    assign casc_here = (c == 0) ? casc_lvl : 1'b0;
    assign pend[PEND_W*c +: PEND_W] = {route_q[c] & pmu_lvl[c],
                                       casc_here,
                                       mbx_en_q[4*c +: 4] & mbox_busy[4*c +: 4],
                                       tmr_en_q[4*c +: 4] & timer_lvl[4*c +: 4]};
    assign core_irq[c] = |pend[PEND_W*c +: PEND_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == PMU_SET || bus_addr == PMU_CLR) bus_rdata = DW'(route_q);
    for (int c = 0; c < NCORE; c++) begin
      if (bus_addr == TMR_BASE + AW'(4*c)) bus_rdata = DW'(tmr_en_q[4*c +: 4]);
      if (bus_addr == MBX_BASE + AW'(4*c)) bus_rdata = DW'(mbx_en_q[4*c +: 4]);
      if (bus_addr == PND_BASE + AW'(4*c)) bus_rdata = DW'(pend[PEND_W*c +: PEND_W]);
    end
  end
endmodule

// File: rtl/core_irq_hub_chk.sv
module core_irq_hub_chk #(
  parameter int NCORE = 4,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic [DW-1:0]      bus_wdata,
  input logic [4*NCORE-1:0] timer_lvl,
  input logic [4*NCORE-1:0] mbox_busy,
  input logic               casc_lvl,
  input logic [NCORE-1:0]   pmu_lvl,
  input logic [NCORE-1:0]   core_irq,
  input logic [4*NCORE-1:0] tmr_en_q,
  input logic [4*NCORE-1:0] mbx_en_q,
  input logic [NCORE-1:0]   route_q
);
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_lvl == '0 && mbox_busy == '0 && !casc_lvl && pmu_lvl == '0) |-> core_irq == '0); // R10

  AST_ROUTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h010)) |=>
      (route_q & $past(bus_wdata[NCORE-1:0])) == $past(bus_wdata[NCORE-1:0])); // R6

  AST_ROUTE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h014)) |=> (route_q & $past(bus_wdata[NCORE-1:0])) == '0); // R7

  AST_PEND_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[AW-1:4] == (AW-4)'(6)) |=>
      ($stable(tmr_en_q) && $stable(mbx_en_q) && $stable(route_q))); // R5

  for (genvar c = 1; c < NCORE; c++) begin : g_casc
    AST_CASC_CORE0: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en_q[4*c +: 4] == '0 && mbx_en_q[4*c +: 4] == '0 && !route_q[c]) |-> !core_irq[c]); // R9
  end
endmodule

bind core_irq_hub core_irq_hub_chk #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .timer_lvl(timer_lvl), .mbox_busy(mbox_busy), .casc_lvl(casc_lvl), .pmu_lvl(pmu_lvl),
  .core_irq(core_irq), .tmr_en_q(tmr_en_q), .mbx_en_q(mbx_en_q), .route_q(route_q)
);

// File: tb/core_irq_hub_tb.sv
module core_irq_hub_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] timer_lvl = '0;
  logic [15:0] mbox_busy = '0;
  logic        casc_lvl = 0;
  logic [3:0]  pmu_lvl = '0;
  logic [3:0]  core_irq;
  int          total = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  core_irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_lvl(timer_lvl), .mbox_busy(mbox_busy), .casc_lvl(casc_lvl),
    .pmu_lvl(pmu_lvl), .core_irq(core_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic irq_is(input string req, input logic [3:0] exp);
    #1 chk(req, {28'd0, core_irq}, {28'd0, exp});
  endtask

  task automatic clear_all();
    for (int c = 0; c < 4; c++) begin
      wr(12'h040 + 12'(4*c), 0);
      wr(12'h050 + 12'(4*c), 0);
    end
    wr(12'h014, 32'hF);
    timer_lvl = '0; mbox_busy = '0; casc_lvl = 0; pmu_lvl = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    timer_lvl = '1; mbox_busy = '1; pmu_lvl = '1;
    irq_is("R1 irq after reset", 4'h0);
    for (int c = 0; c < 4; c++) begin
      rd(12'h040 + 12'(4*c), d); chk("R1 timer enable reset", d, 0);
      rd(12'h050 + 12'(4*c), d); chk("R1 mailbox enable reset", d, 0);
      rd(12'h060 + 12'(4*c), d); chk("R1 pending reset", d, 0);
    end
    rd(12'h010, d); chk("R1 routing reset", d, 0);
    timer_lvl = '0; mbox_busy = '0; pmu_lvl = '0;
  endtask

  task automatic t_timer();
    logic [31:0] d;
    logic [3:0] m;
    clear_all();
    timer_lvl = 16'hFFFF;
    for (int c = 0; c < 4; c++) wr(12'h040 + 12'(4*c), 32'hFFFF_FFF0 | 32'(4'b0001 << c));
    for (int c = 0; c < 4; c++) begin
      m = 4'b0001 << c;
      rd(12'h040 + 12'(4*c), d); chk("R2 timer enable readback", d, {28'd0, m});
      rd(12'h060 + 12'(4*c), d); chk("R4 timer pending bits", d, {28'd0, m});
    end
    irq_is("R10 irq from timers", 4'hF);
    timer_lvl = 16'hFFFF & ~16'h0001;
    irq_is("R10 core 0 timer dropped", 4'hE);
    timer_lvl = 16'h0000;
    #1 rd(12'h060 + 12'd4, d); chk("R4 no latching after source drop", d, 0);
    irq_is("R4 irq follows level", 4'h0);
  endtask

  task automatic t_mailbox();
    logic [31:0] d;
    clear_all();
    mbox_busy = 16'hFFFF;
    for (int c = 0; c < 4; c++) wr(12'h050 + 12'(4*c), 32'(4'b1000 >> c));
    for (int c = 0; c < 4; c++) begin
      rd(12'h050 + 12'(4*c), d); chk("R3 mailbox enable readback", d, 32'(4'b1000 >> c));
      rd(12'h060 + 12'(4*c), d); chk("R4 mailbox pending bits 7:4", d, 32'(4'b1000 >> c) << 4);
    end
    mbox_busy = 16'h0F0F & 16'hFFFF;
    irq_is("R3 only cores with enabled busy mailbox", 4'b0101);
  endtask

  task automatic t_cascade();
    logic [31:0] d;
    clear_all();
    casc_lvl = 1;
    rd(12'h060, d); chk("R9 cascade in core 0 bit 8", d, 32'h100);
    for (int c = 1; c < 4; c++) begin
      rd(12'h060 + 12'(4*c), d); chk("R9 cascade absent on other cores", d, 0);
    end
    irq_is("R9 cascade raises core 0 only", 4'b0001);
    casc_lvl = 0;
    irq_is("R9 cascade drop", 4'b0000);
  endtask

  task automatic t_pmu();
    logic [31:0] d;
    clear_all();
    pmu_lvl = 4'hF;
    wr(12'h010, 32'hFFFF_FFF5);
    rd(12'h010, d); chk("R8 routing read at set offset", d, 32'h5);
    irq_is("R6 pmu irq on routed cores", 4'b0101);
    rd(12'h068, d); chk("R4 pmu pending bit 9", d, 32'h200);
    wr(12'h010, 32'h2);
    rd(12'h010, d); chk("R6 set ORs into mask", d, 32'h7);
    wr(12'h014, 32'h4);
    rd(12'h014, d); chk("R7 clear removes only selected bits", d, 32'h3);
    irq_is("R7 pmu irq after clear", 4'b0011);
    pmu_lvl = 4'b0001;
    irq_is("R6 routed but inactive core quiet", 4'b0001);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    clear_all();
    timer_lvl = 16'hFFFF; mbox_busy = 16'hFFFF; pmu_lvl = 4'hF;
    for (int c = 0; c < 4; c++) wr(12'h060 + 12'(4*c), 32'hFFFF_FFFF);
    irq_is("R5 pending write raises no irq", 4'h0);
    rd(12'h040, d); chk("R5 timer enable untouched", d, 0);
    rd(12'h054, d); chk("R5 mailbox enable untouched", d, 0);
    rd(12'h010, d); chk("R5 routing untouched", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    clear_all();
    wr(12'h040, 32'h3);
    timer_lvl = 16'hFFFF; mbox_busy = 16'hFFFF; pmu_lvl = 4'hF;
    rd(12'h000, d); chk("R11 unmapped read 0x000", d, 0);
    rd(12'h020, d); chk("R11 unmapped read 0x020", d, 0);
    rd(12'h070, d); chk("R11 unmapped read 0x070", d, 0);
    rd(12'h0FC, d); chk("R11 unmapped read 0x0FC", d, 0);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h070, 32'hFFFF_FFFF);
    wr(12'h018, 32'hFFFF_FFFF);
    irq_is("R11 unmapped writes change nothing", 4'b0001);
    rd(12'h060, d); chk("R11 core 0 pending unchanged", d, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_timer();
    t_mailbox();
    t_cascade();
    t_pmu();
    t_readonly();
    t_unmapped();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule